// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the clock waveform a bus master drives onto SCL. It splits each SCL period into a low phase and a high phase. Each phase has its own programmed count, and the counts run on a tick that can come from several sources. The tick can be the bus clock itself, one of three slower base-clock ticks, or the fourth base-clock tick slowed further by a power-of-two prescale. The block does not drive SCL high. It only requests that the line be pulled low. It watches the sampled line so that it can follow a slave that stretches the clock, and so that it can follow another master that pulls SCL low early.

A data shifter uses two one-cycle strobes to mark the start of each low phase and the start of high-phase counting. A separate watchdog counts slow prescaled ticks while SCL stays low and raises a sticky timeout flag, which supports bus-hang recovery of the SMBus kind. Byte framing and START/STOP sequencing belong to the block that uses these strobes.

Top module: `scl_timing_gen`

## Requirements
- R1: The tick source is chosen by the 4-bit `cfg_clk_sel`. Value 0 ticks every bus-clock cycle. Values 1, 2 and 3 use `base_tick[0]`, `base_tick[1]` and `base_tick[2]`. Any value S of 4 or more uses one tick out of every 2^(S-4) pulses of `base_tick[3]`.
- R2: Once a low phase starts, `scl_drive_low` stays at 1 for `cfg_low_cnt`+1 ticks.
- R3: When the sampled line follows the drive, SCL is released for `cfg_high_cnt`+1 ticks. A full period is therefore `cfg_low_cnt`+`cfg_high_cnt`+2 ticks.
- R4: After release, high counting waits until `scl_in` reads 1. While an external device holds the line low, no new low phase begins. Once the line reads high, the next low phase starts after `cfg_high_cnt`+1 ticks.
- R5: Suppose `scl_in` reads 0 during high counting after at least `cfg_high_min` ticks have been counted. The low phase then begins at the next clock edge. Below that count, the low reading is ignored and high counting continues.
- R6: `phase_fall` is 1 for exactly the first cycle of each low phase. `phase_rise` is 1 for one cycle, one clock after the tick that starts high counting.
- R7: The timeout tick is `base_tick[3]` divided by 2^`cfg_tmo_div`. While `scl_in` is 0, these ticks are counted. When the count reaches `cfg_tmo_limit`, `tmo_flag` sets and stays set. Whenever `scl_in` reads 1, the count restarts from zero.
- R8: When `cfg_tmo_limit` is 0, `tmo_flag` never sets.
- R9: While `enable` is 0, the block releases SCL, clears `tmo_flag` and both strobes, and idles, all from the next clock edge. When `enable` returns to 1, a low phase begins at the next edge.
- R10: Synchronous `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; 0 idles and clears state |
| base_tick | input | 4 | One-cycle pulses of the four base clocks |
| cfg_clk_sel | input | 4 | Tick source select |
| cfg_low_cnt | input | 4 | Low phase length minus one, in ticks |
| cfg_high_cnt | input | 4 | High phase length minus one, in ticks |
| cfg_high_min | input | 4 | High ticks required before an external low ends the high phase |
| cfg_tmo_div | input | 4 | Power-of-two prescale of base tick 4 for the timeout |
| cfg_tmo_limit | input | 4 | Timeout length in prescaled ticks; 0 disables |
| scl_in | input | 1 | Sampled SCL line |
| scl_drive_low | output | 1 | Request to pull SCL low |
| phase_fall | output | 1 | Strobe on the first cycle of a low phase |
| phase_rise | output | 1 | Strobe when high-phase counting starts |
| tmo_flag | output | 1 | Sticky SCL-low timeout |

## Verification
The bench builds the block with its default parameters: four base ticks and a 16-bit prescale counter. With these, selector values 4, 5 and 6 exercise prescale shifts of 0, 1 and 2. The bench drives the base ticks with distinct periods of 3, 5, 7 and 2 bus clocks, so a wrong source choice or a wrong prescale shows up as a wrong phase length. The sampled line is modelled as the drive combined with an external hold. This lets the bench reach clock stretching, early low by another master on either side of the minimum-high count, and a line held low long enough to trip the timeout.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam int CFG_W    = 4;
  localparam int NUM_BASE = 4;
  localparam int PRESC_W  = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HWAIT = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;
endpackage

// File: rtl/pow2_prescaler.sv
module pow2_prescaler #(
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               in_tick,
  input  logic [SHIFT_W-1:0] shift,
  output logic               out_tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < int'(shift));
    end
  end

  assign out_tick = in_tick && (&(cnt | ~mask));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (in_tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_tick_sel.sv
module scl_tick_sel
  import scl_timing_pkg::*;
#(
  parameter int NB = NUM_BASE,
  parameter int SW = CFG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [NB-1:0] base_tick,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  logic          slow_tick;
  logic [SW-1:0] shift;

  assign shift = sel - SW'(NB);

  pow2_prescaler #(.CNT_W(PRESC_W), .SHIFT_W(SW)) u_slow (
    .clk      (clk),
    .rst      (rst),
    .clr      (!enable),
    .in_tick  (base_tick[NB-1]),
    .shift    (shift),
    .out_tick (slow_tick)
  );

  always_comb begin
    tick = slow_tick;
    if (sel == '0) begin
      tick = 1'b1;
    end else begin
      for (int i = 1; i < NB; i++) begin
        if (sel == SW'(i)) tick = base_tick[i-1];
      end
    end
  end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_timing_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         tick,
  input  logic         scl_in,
  input  logic [W-1:0] low_cnt,
  input  logic [W-1:0] high_cnt,
  input  logic [W-1:0] high_min,
  output logic         drive_low,
  output logic         fall_stb,
  output logic         rise_stb
);
  phase_e       state;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      drive_low <= 1'b0;
      fall_stb  <= 1'b0;
      rise_stb  <= 1'b0;
    end else begin
      fall_stb <= 1'b0;
      rise_stb <= 1'b0;
      case (state)
        PH_IDLE: begin
          state     <= PH_LOW;
          cnt       <= '0;
          drive_low <= 1'b1;
          fall_stb  <= 1'b1;
        end
        PH_LOW: begin
          if (tick) begin
            if (cnt == low_cnt) begin
              state     <= PH_HWAIT;
              cnt       <= '0;
              drive_low <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_HWAIT: begin
          if (scl_in && tick) begin
            rise_stb <= 1'b1;
            if (high_cnt == '0) begin
              state     <= PH_LOW;
              cnt       <= '0;
              drive_low <= 1'b1;
              fall_stb  <= 1'b1;
            end else begin
              state <= PH_HIGH;
              cnt   <= W'(1);
            end
          end
        end
        default: begin
          if ((!scl_in && cnt >= high_min) || (tick && cnt == high_cnt)) begin
            state     <= PH_LOW;
            cnt       <= '0;
            drive_low <= 1'b1;
            fall_stb  <= 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_low_timeout.sv
module scl_low_timeout
  import scl_timing_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         src_tick,
  input  logic [W-1:0] div,
  input  logic [W-1:0] limit,
  input  logic         scl_in,
  output logic         flag
);
  logic         tmo_tick;
  logic [W-1:0] cnt;

  pow2_prescaler #(.CNT_W(PRESC_W), .SHIFT_W(W)) u_tmo_presc (
    .clk      (clk),
    .rst      (rst),
    .clr      (!enable),
    .in_tick  (src_tick),
    .shift    (div),
    .out_tick (tmo_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (scl_in) begin
      cnt <= '0;
    end else if (tmo_tick && limit != '0) begin
      if (({1'b0, cnt} + 1'b1) == {1'b0, limit}) flag <= 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [NUM_BASE-1:0] base_tick,
  input  logic [CFG_W-1:0]    cfg_clk_sel,
  input  logic [CFG_W-1:0]    cfg_low_cnt,
  input  logic [CFG_W-1:0]    cfg_high_cnt,
  input  logic [CFG_W-1:0]    cfg_high_min,
  input  logic [CFG_W-1:0]    cfg_tmo_div,
  input  logic [CFG_W-1:0]    cfg_tmo_limit,
  input  logic                scl_in,
  output logic                scl_drive_low,
  output logic                phase_fall,
  output logic                phase_rise,
  output logic                tmo_flag
);
  logic tick;

  scl_tick_sel #(.NB(NUM_BASE), .SW(CFG_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .base_tick (base_tick),
    .sel       (cfg_clk_sel),
    .tick      (tick)
  );

  scl_phase_fsm #(.W(CFG_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .tick      (tick),
    .scl_in    (scl_in),
    .low_cnt   (cfg_low_cnt),
    .high_cnt  (cfg_high_cnt),
    .high_min  (cfg_high_min),
    .drive_low (scl_drive_low),
    .fall_stb  (phase_fall),
    .rise_stb  (phase_rise)
  );

  scl_low_timeout #(.W(CFG_W)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .src_tick (base_tick[NUM_BASE-1]),
    .div      (cfg_tmo_div),
    .limit    (cfg_tmo_limit),
    .scl_in   (scl_in),
    .flag     (tmo_flag)
  );
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk
  import scl_timing_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [CFG_W-1:0] cfg_tmo_limit,
  input logic             scl_drive_low,
  input logic             phase_fall,
  input logic             tmo_flag
);
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_drive_low && !tmo_flag)); // R9

  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (rst)
    phase_fall |-> scl_drive_low); // R6

  AST_LOW_STARTS_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> phase_fall); // R6

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag && enable) |=> tmo_flag); // R7

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_tmo_limit == '0 && !tmo_flag) |=> !tmo_flag); // R8
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .enable        (enable),
  .cfg_tmo_limit (cfg_tmo_limit),
  .scl_drive_low (scl_drive_low),
  .phase_fall    (phase_fall),
  .tmo_flag      (tmo_flag)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int CLK_PERIOD = 10;
  // {sel, low, high, expected low clocks, expected high clocks}
  localparam logic [27:0] VEC [9] = '{
    {4'd0, 4'd3,  4'd2,  8'd4,  8'd3},
    {4'd0, 4'd0,  4'd0,  8'd1,  8'd1},
    {4'd1, 4'd2,  4'd1,  8'd9,  8'd6},
    {4'd2, 4'd1,  4'd3,  8'd10, 8'd20},
    {4'd3, 4'd0,  4'd1,  8'd7,  8'd14},
    {4'd4, 4'd1,  4'd1,  8'd4,  8'd4},
    {4'd5, 4'd2,  4'd0,  8'd12, 8'd4},
    {4'd6, 4'd0,  4'd0,  8'd8,  8'd8},
    {4'd0, 4'd15, 4'd15, 8'd16, 8'd16}
  };

  logic clk = 1'b0;
  logic rst, enable, ext_hold;
  logic [3:0] base_tick;
  logic [3:0] sel, lo, hi, hmin, tdiv, tlim;
  logic scl_in, drv, fall, rise, tmo;
  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_in = !(drv || ext_hold);

  scl_timing_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .base_tick(base_tick),
    .cfg_clk_sel(sel), .cfg_low_cnt(lo), .cfg_high_cnt(hi),
    .cfg_high_min(hmin), .cfg_tmo_div(tdiv), .cfg_tmo_limit(tlim),
    .scl_in(scl_in), .scl_drive_low(drv), .phase_fall(fall),
    .phase_rise(rise), .tmo_flag(tmo)
  );

  // base tick periods 3, 5, 7, 2 clocks
  initial begin
    int c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    base_tick = '0;
    forever begin
      @(negedge clk);
      base_tick = {c3 == 0, c2 == 0, c1 == 0, c0 == 0};
      c0 = (c0 + 1) % 3; c1 = (c1 + 1) % 5;
      c2 = (c2 + 1) % 7; c3 = (c3 + 1) % 2;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input logic v);
    while (drv !== v) @(negedge clk);
  endtask

  task automatic setup(input logic [3:0] s, input logic [3:0] l,
                       input logic [3:0] h, input logic [3:0] m);
    enable = 1'b0;
    @(negedge clk);
    sel = s; lo = l; hi = h; hmin = m;
    enable = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int lc, hc, n;
    rst = 1'b1; enable = 1'b1; ext_hold = 1'b0;
    sel = '0; lo = 4'd3; hi = 4'd2; hmin = '0; tdiv = 4'd1; tlim = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 drive", drv, 0);
    check("R10 strobes", fall | rise, 0);
    check("R10 timeout", tmo, 0);
    rst = 1'b0;
    enable = 1'b0;
    @(negedge clk);

    // R1 R2 R3 table walk: second full period of each setting
    for (int i = 0; i < 9; i++) begin
      setup(VEC[i][27:24], VEC[i][23:20], VEC[i][19:16], 4'd0);
      wait_level(1'b1); wait_level(1'b0); wait_level(1'b1);
      lc = 0;
      while (drv) begin lc++; @(negedge clk); end
      hc = 0;
      while (!drv) begin hc++; @(negedge clk); end
      check($sformatf("R1 R2 low clocks vec%0d", i), lc, int'(VEC[i][15:8]));
      check($sformatf("R1 R3 high clocks vec%0d", i), hc, int'(VEC[i][7:0]));
    end

    // R9 re-enable begins low at once, R6 fall strobe only first cycle
    setup(4'd0, 4'd3, 4'd2, 4'd0);
    @(negedge clk);
    check("R9 low after enable", drv, 1);
    check("R6 fall on first low cycle", fall, 1);
    @(negedge clk);
    check("R6 fall cleared", fall, 0);
    wait_level(1'b0);
    check("R6 no rise at release", rise, 0);
    @(negedge clk);
    check("R6 rise one clock after release", rise, 1);
    @(negedge clk);
    check("R6 rise cleared", rise, 0);
    enable = 1'b0;
    @(negedge clk);
    check("R9 disabled drive", drv, 0);
    check("R9 disabled strobes", fall | rise, 0);

    // R4 stretching
    setup(4'd0, 4'd1, 4'd2, 4'd0);
    wait_level(1'b1);
    ext_hold = 1'b1;
    wait_level(1'b0);
    repeat (10) @(negedge clk);
    check("R4 no low while stretched", drv, 0);
    ext_hold = 1'b0;
    n = 0;
    while (!drv) begin n++; @(negedge clk); end
    check("R4 high ticks after stretch", n, 3);

    // R5 early low after min-high
    setup(4'd0, 4'd2, 4'd10, 4'd1);
    wait_level(1'b1); wait_level(1'b0);
    repeat (3) @(negedge clk);
    ext_hold = 1'b1;
    @(negedge clk);
    check("R5 early low past min", drv, 1);
    ext_hold = 1'b0;
    setup(4'd0, 4'd2, 4'd10, 4'd12);
    wait_level(1'b1); wait_level(1'b0);
    repeat (3) @(negedge clk);
    ext_hold = 1'b1;
    @(negedge clk);
    check("R5 low ignored below min", drv, 0);
    ext_hold = 1'b0;

    // R7 timeout: base tick 4 / 2 -> every 4 clocks, limit 3
    enable = 1'b0;
    @(negedge clk);
    tdiv = 4'd1; tlim = 4'd3; ext_hold = 1'b1;
    enable = 1'b1;
    repeat (6) @(negedge clk);
    check("R7 not yet expired", tmo, 0);
    repeat (10) @(negedge clk);
    check("R7 expired", tmo, 1);
    ext_hold = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 sticky", tmo, 1);
    enable = 1'b0;
    @(negedge clk);
    check("R9 flag cleared", tmo, 0);

    // R7 count restarts on high: 4-clock lows never reach 3 ticks
    setup(4'd0, 4'd3, 4'd2, 4'd0);
    repeat (200) @(negedge clk);
    check("R7 restart on high", tmo, 0);

    // R8 limit zero disables
    enable = 1'b0;
    @(negedge clk);
    tlim = 4'd0; ext_hold = 1'b1;
    enable = 1'b1;
    repeat (80) @(negedge clk);
    check("R8 no timeout at limit 0", tmo, 0);
    ext_hold = 1'b0;

    summary();
    $finish;
  end
endmodule